// File: doc/BRIEF.md
# Square-Wave Output Controller

This block holds the one-byte control register of a timekeeping device and drives its square-wave pin. The pin either carries a divided copy of the 32.768 kHz timebase at one of four rates or sits at a static level chosen by software. The pin is open drain, so the block's output is a pull-low enable. A sticky flag records that the oscillator stopped. Software can only clear the flag.

The timebase arrives as a one-cycle pulse `osc_tick` in the system clock domain, once per oscillator edge. That is twice the crystal frequency, 65,536 pulses a second. A prescaler counts these pulses. A write to the seconds register, signalled by `sec_wr`, clears the prescaler so that the slowest rate is phase-aligned to the new second. The clock-halt control `osc_halt` blocks the pulses. A gap counter raises the stop flag once no pulse has arrived for `STOP_LIMIT` system cycles.

Top module: `sqw_out_ctrl`

## Requirements
- R1: After reset the register reads 0xB3: static level 1, stop flag 1, wave enable 1 and rate code 11.
- R2: The read byte places the static level at bit 7, the stop flag at bit 5, the wave enable at bit 4 and the rate code at bits 1:0. Bits 6, 3 and 2 always read 0. A write updates bits 7, 4 and 1:0 from the same positions.
- R3: With wave enable 0, the pin level equals the static-level bit one cycle after the register changes, whatever the timebase does.
- R4: With wave enable 1, the pin level toggles every 2^(DIV_BITS-1) timebase pulses for rate 00, every 8 for rate 01, every 4 for rate 10 and every pulse for rate 11.
- R5: With rate 00 and wave enable 1, a seconds write drives the pin low on the following cycle. The pin then rises once 2^(DIV_BITS-1) further timebase pulses have been counted.
- R6: A write with bit 5 = 0 clears the stop flag. A write with bit 5 = 1 leaves the flag unchanged.
- R7: The stop flag is set STOP_LIMIT cycles after the last timebase pulse, and not earlier.
- R8: The stop flag is set only on the transition from running to stopped. If software clears it while the stop persists, it stays clear until pulses resume and then stop again.
- R9: Halt blocks the timebase. The prescaler and the pin freeze, and the halt counts as a stop for the flag.
- R10: `sqw_drive_low` is the inverse of the pin level: 1 pulls the pin low and 0 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One pulse per oscillator edge |
| osc_halt | input | 1 | Clock-halt control, blocks the timebase |
| sec_wr | input | 1 | Pulse on a seconds-register write |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read data |
| sqw_drive_low | output | 1 | Open-drain pull-low enable for the pin |

## Verification
The bench builds the block with DIV_BITS = 6 and STOP_LIMIT = 20, and pulses the timebase on every cycle. With these values the slow rate has a half period of 32 cycles, so both its period and its alignment to a seconds write can be measured in full. The stop detector fires after 20 quiet cycles. This makes the exact set cycle reachable, as are the sticky behaviour under a lasting stop and re-arming after pulses resume.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_4K   = 2'b01,
        RATE_8K   = 2'b10,
        RATE_32K  = 2'b11
    } rate_e;

    typedef struct packed {
        logic  lvl_static;
        logic  stop_flag;
        logic  wave_en;
        rate_e rate;
    } ctrl_t;

    localparam int unsigned BIT_STATIC = 7;
    localparam int unsigned BIT_STOP   = 5;
    localparam int unsigned BIT_WAVE   = 4;

    localparam int unsigned TAP_4K  = 3;
    localparam int unsigned TAP_8K  = 2;
    localparam int unsigned TAP_32K = 0;

    localparam ctrl_t CTRL_RESET = '{
        lvl_static: 1'b1,
        stop_flag:  1'b1,
        wave_en:    1'b1,
        rate:       RATE_32K
    };

    function automatic logic [7:0] ctrl_to_byte(ctrl_t c);
        logic [7:0] b;
        b             = '0;
        b[BIT_STATIC] = c.lvl_static;
        b[BIT_STOP]   = c.stop_flag;
        b[BIT_WAVE]   = c.wave_en;
        b[1:0]        = c.rate;
        return b;
    endfunction

endpackage

// File: rtl/sqw_ctrl_reg.sv
module sqw_ctrl_reg
    import sqw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       stop_set,
    output ctrl_t      ctrl_q
);

    logic unused_rsvd;
    assign unused_rsvd = ^{wdata[6], wdata[3:2]};

    logic clear_req;
    assign clear_req = wr_en && !wdata[BIT_STOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            if (wr_en) begin
                ctrl_q.lvl_static <= wdata[BIT_STATIC];
                ctrl_q.wave_en    <= wdata[BIT_WAVE];
                ctrl_q.rate       <= rate_e'(wdata[1:0]);
            end
            // a detected stop wins over a clear in the same cycle
            ctrl_q.stop_flag <= stop_set || (ctrl_q.stop_flag && !clear_req);
        end
    end

endmodule

// File: rtl/sqw_stop_watch.sv
module sqw_stop_watch #(
    parameter int unsigned STOP_LIMIT = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic stop_set
);

    localparam int unsigned   GAP_W = $clog2(STOP_LIMIT + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(STOP_LIMIT);

    logic [GAP_W-1:0] gap_q;

    // starts saturated: the reset value of the flag already marks the stop
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GAP_MAX;
        end else if (tick) begin
            gap_q <= '0;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign stop_set = !tick && (gap_q == GAP_MAX - 1'b1);

endmodule

// File: rtl/sqw_divider.sv
module sqw_divider
    import sqw_pkg::*;
#(
    parameter int unsigned DIV_BITS = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  align,
    input  logic  wave_en,
    input  logic  lvl_static,
    input  rate_e rate,
    output logic  pin_level
);

    logic [DIV_BITS-1:0] cnt_q;
    logic [3:0]          taps;
    logic                lvl_q;
    logic                unused_div;

    always_ff @(posedge clk) begin
        if (rst || align) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign taps[RATE_SLOW] = cnt_q[DIV_BITS-1];
    assign taps[RATE_4K]   = cnt_q[TAP_4K];
    assign taps[RATE_8K]   = cnt_q[TAP_8K];
    assign taps[RATE_32K]  = cnt_q[TAP_32K];
    assign unused_div      = ^cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b1;
        end else begin
            lvl_q <= wave_en ? taps[rate] : lvl_static;
        end
    end

    assign pin_level = lvl_q;

endmodule

// File: rtl/sqw_out_ctrl.sv
module sqw_out_ctrl
    import sqw_pkg::*;
#(
    parameter int unsigned DIV_BITS   = 16,
    parameter int unsigned STOP_LIMIT = 1_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       osc_halt,
    input  logic       sec_wr,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    output logic       sqw_drive_low
);

    ctrl_t ctrl;
    logic  tick_run;
    logic  stop_set;
    logic  pin_level;

    assign tick_run = osc_tick && !osc_halt;

    sqw_ctrl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctrl_wr),
        .wdata    (ctrl_wdata),
        .stop_set (stop_set),
        .ctrl_q   (ctrl)
    );

    sqw_stop_watch #(.STOP_LIMIT(STOP_LIMIT)) u_watch (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_run),
        .stop_set (stop_set)
    );

    sqw_divider #(.DIV_BITS(DIV_BITS)) u_div (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_run),
        .align      (sec_wr),
        .wave_en    (ctrl.wave_en),
        .lvl_static (ctrl.lvl_static),
        .rate       (ctrl.rate),
        .pin_level  (pin_level)
    );

    assign ctrl_rdata    = ctrl_to_byte(ctrl);
    assign sqw_drive_low = !pin_level;

endmodule

// File: rtl/sqw_out_ctrl_chk.sv
module sqw_out_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       osc_tick,
    input logic       osc_halt,
    input logic       sec_wr,
    input logic       ctrl_wr,
    input logic       ctrl_wdata_b5,
    input logic [7:0] ctrl_rdata,
    input logic       sqw_drive_low
);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[6] == 1'b0) && (ctrl_rdata[3:2] == 2'b00));

    // R6
    flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_rdata[5]) |-> $past(ctrl_wr && !ctrl_wdata_b5));

    // R7
    flag_set_needs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_rdata[5]) |-> $past(!osc_tick || osc_halt));

    // R3
    static_level_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!ctrl_rdata[4]) |-> (sqw_drive_low == $past(!ctrl_rdata[7])));

    // R5
    align_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_wr && !ctrl_wr && ctrl_rdata[4] && ctrl_rdata[1:0] == 2'b00)
        |-> ##2 sqw_drive_low);

endmodule

bind sqw_out_ctrl sqw_out_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .osc_tick      (osc_tick),
    .osc_halt      (osc_halt),
    .sec_wr        (sec_wr),
    .ctrl_wr       (ctrl_wr),
    .ctrl_wdata_b5 (ctrl_wdata[5]),
    .ctrl_rdata    (ctrl_rdata),
    .sqw_drive_low (sqw_drive_low)
);

// File: tb/sqw_out_ctrl_bench.sv
`timescale 1ns/1ps
module sqw_out_ctrl_bench;

    localparam int DIV_BITS   = 6;
    localparam int STOP_LIMIT = 20;
    localparam int SEL_BYTE   = 0;
    localparam int SEL_FLAG   = 1;
    localparam int SEL_PIN    = 2;

    logic       clk = 1'b0;
    logic       rst, osc_tick, osc_halt, sec_wr, ctrl_wr;
    logic [7:0] ctrl_wdata, ctrl_rdata;
    logic       sqw_drive_low;

    always #2.5 clk = ~clk;

    sqw_out_ctrl #(.DIV_BITS(DIV_BITS), .STOP_LIMIT(STOP_LIMIT)) u_sqw_out_ctrl (
        .clk           (clk),
        .rst           (rst),
        .osc_tick      (osc_tick),
        .osc_halt      (osc_halt),
        .sec_wr        (sec_wr),
        .ctrl_wr       (ctrl_wr),
        .ctrl_wdata    (ctrl_wdata),
        .ctrl_rdata    (ctrl_rdata),
        .sqw_drive_low (sqw_drive_low)
    );

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_port(string req, int sel, logic [7:0] exp);
        sb_q.push_back('{req, sel, exp});
    endtask

    // monitor: compares queued expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t      it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.sel)
                    SEL_BYTE: act = ctrl_rdata;
                    SEL_FLAG: act = {7'b0, ctrl_rdata[5]};
                    default:  act = {7'b0, sqw_drive_low};
                endcase
                chk(it.req, int'(act), int'(it.exp));
            end
        end
    end

    task automatic wr_ctrl(logic [7:0] d);
        ctrl_wr    = 1'b1;
        ctrl_wdata = d;
        @(negedge clk);
        ctrl_wr    = 1'b0;
    endtask

    task automatic measure_half(output int n);
        logic prev;
        prev = sqw_drive_low;
        do @(negedge clk); while (sqw_drive_low == prev);
        prev = sqw_drive_low;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sqw_drive_low == prev && n < 200);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int c;
        int flips;
        logic ref_lvl;
        rst = 1'b1; osc_tick = 1'b1; osc_halt = 1'b0; sec_wr = 1'b0;
        ctrl_wr = 1'b0; ctrl_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset value
        expect_port("R1", SEL_BYTE, 8'hB3);
        @(negedge clk);

        // R3 / R10 static level high, clear flag (R6)
        wr_ctrl(8'h80);
        expect_port("R2", SEL_BYTE, 8'h80);
        expect_port("R6", SEL_FLAG, 8'd0);
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            expect_port("R3", SEL_PIN, 8'd0);
            repeat (5) @(negedge clk);
        end
        wr_ctrl(8'h03);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            expect_port("R10", SEL_PIN, 8'd1);
            repeat (7) @(negedge clk);
        end

        // R2 reserved bits, R6 write of 1 keeps cleared flag
        wr_ctrl(8'hFF);
        expect_port("R2", SEL_BYTE, 8'h93);
        expect_port("R6", SEL_FLAG, 8'd0);
        @(negedge clk);

        // R4 rates
        for (int r = 3; r >= 0; r--) begin
            int exp_half;
            exp_half = (r == 3) ? 1 : (r == 2) ? 4 : (r == 1) ? 8 : (1 << (DIV_BITS - 1));
            wr_ctrl(8'h90 | 8'(r));
            measure_half(n);
            measure_half(n);
            chk("R4", n, exp_half);
        end

        // R5 alignment to a seconds write (rate 00 selected)
        repeat (10) @(negedge clk);
        sec_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sec_wr = 1'b0;
        @(negedge clk);
        c = 1;
        chk("R5", int'(sqw_drive_low), 1);
        while (sqw_drive_low && c < 200) begin
            @(negedge clk);
            c++;
        end
        chk("R5", c, (1 << (DIV_BITS - 1)) + 1);

        // R7 stop detection timing
        osc_tick = 1'b0;
        repeat (STOP_LIMIT - 2) @(negedge clk);
        chk("R7", int'(ctrl_rdata[5]), 0);
        repeat (3) @(negedge clk);
        chk("R7", int'(ctrl_rdata[5]), 1);

        // R6 write with bit 5 = 1 leaves a set flag set
        wr_ctrl(8'hB0);
        expect_port("R6", SEL_FLAG, 8'd1);
        @(negedge clk);

        // R8 cleared during a lasting stop stays clear
        wr_ctrl(8'h90);
        repeat (2 * STOP_LIMIT) @(negedge clk);
        expect_port("R8", SEL_FLAG, 8'd0);
        @(negedge clk);
        osc_tick = 1'b1;
        repeat (5) @(negedge clk);
        osc_tick = 1'b0;
        repeat (STOP_LIMIT + 3) @(negedge clk);
        expect_port("R8", SEL_FLAG, 8'd1);
        @(negedge clk);

        // R9 halt freezes the pin and sets the flag
        osc_tick = 1'b1;
        wr_ctrl(8'h93);
        repeat (5) @(negedge clk);
        osc_halt = 1'b1;
        repeat (3) @(negedge clk);
        ref_lvl = sqw_drive_low;
        flips = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (sqw_drive_low != ref_lvl) flips++;
        end
        chk("R9", flips, 0);
        repeat (STOP_LIMIT) @(negedge clk);
        chk("R9", int'(ctrl_rdata[5]), 1);
        osc_halt = 1'b0;
        measure_half(n);
        measure_half(n);
        chk("R9", n, 1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule